// File: doc/BRIEF.md
# Endpoint-Zero Handshake Gate

This block decides, for endpoint 0 of a USB device, whether a host OUT token is refused with NAK or its data is accepted, and whether a host IN token is refused with NAK or answered with data. The decisions come from two state bits kept in an 8-bit register that firmware can read. The receive bit means "refuse" when set. The transmit bit has the opposite sense and means "data ready to send" when set.

Both bits follow events reported by the endpoint-0 buffers. A good OUT packet or firmware setting the bit starts receive NAK. Draining the receive buffer, a firmware write of 0, or a receive-buffer clear ends it. A full transmit buffer or a short-packet end flag arms transmit. A host ACK, a status stage reached without a data-stage ACK, or a transmit-buffer clear disarms it. Buffer-clear commands from firmware reach the bits only after a fixed pipeline delay. The packet engine samples the per-token outputs while a token strobe is high.

Top module: `ep0_nak_ctrl`

## Requirements
- R1: After reset the register reads 0x00. Bits 7 to 2 read 0 at all times.
- R2: While `out_tok` is high, `out_nak` is 1 and `out_ack` is 0 if register bit 1 (receive refuse) is 1. If bit 1 is 0, the reverse holds. Both outputs are 0 while `out_tok` is low.
- R3: While `in_tok` is high, `in_nak` is 1 and `in_send` is 0 if register bit 0 (transmit ready) is 0. If bit 0 is 1, the reverse holds. Both outputs are 0 while `in_tok` is low.
- R4: A cycle with `rx_good` high sets bit 1 at the next edge. A cycle with `rx_drained` high clears it at the next edge.
- R5: A write with `fw_wr` high and `ep_nak_busy` low loads bit 1 from `fw_wdata[1]`. The written bit 0 and bits 7 to 2 have no effect on the register.
- R6: A write made while `ep_nak_busy` is high leaves bit 1 unchanged.
- R7: `tx_full` or `tx_short_end` sets bit 0 at the next edge. `tx_host_ack` clears it at the next edge.
- R8: `status_no_ack` clears bit 0 at the next edge.
- R9: A one-cycle `rx_clr_cmd` or `tx_clr_cmd` sampled at edge e clears bit 1 or bit 0 at edge e+CLR_DELAY-1, which is five edges counting e for the default. Before that edge the bit still follows its other events.
- R10: When a set and a clear condition for one bit meet at the same edge, the clear wins. A delayed buffer clear overrides every other event, including a firmware set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fw_wr | input | 1 | Firmware write strobe for the register |
| fw_wdata | input | REG_W | Firmware write data; only bit 1 is used |
| fw_rdata | output | REG_W | Register read value |
| rx_good | input | 1 | Endpoint 0 received a data packet without error |
| rx_drained | input | 1 | Receive buffer read down to zero count |
| rx_clr_cmd | input | 1 | Firmware command clearing the receive buffer |
| ep_nak_busy | input | 1 | NAK currently sent for endpoint-0 read or endpoint 2 |
| tx_host_ack | input | 1 | Host acknowledged the endpoint-0 IN data |
| tx_full | input | 1 | Transmit buffer became full |
| tx_short_end | input | 1 | Short-packet end flag written to 1 |
| tx_clr_cmd | input | 1 | Firmware command clearing the transmit buffer |
| status_no_ack | input | 1 | Status stage entered without a valid data-stage ACK |
| out_tok | input | 1 | OUT token to endpoint 0 being handled |
| in_tok | input | 1 | IN token to endpoint 0 being handled |
| out_nak | output | 1 | Answer the OUT token with NAK |
| out_ack | output | 1 | Accept the OUT data |
| in_nak | output | 1 | Answer the IN token with NAK |
| in_send | output | 1 | Send the held IN data |

## Verification
Directed phases first test each event by itself on each bit. This separates a polarity error in the token decisions from a wrong set or clear source. Next come same-cycle collisions: a good receive together with a drain, a full buffer together with a host ACK, and a firmware set against a pending delayed clear. These show whether the clear priority is correct. A clear command is then tracked edge by edge to pin the delay to exactly the parameter value. Writes with stray bits and writes made while the busy input is high show whether the masking is correct. A long stretch of random events, compared every cycle against a behavioural model, catches interactions that the directed phases miss.

// File: rtl/ep0nak_pkg.sv
package ep0nak_pkg;

   // register bit positions the firmware decodes
   localparam int RX_NAK_POS = 1;
   localparam int TX_RDY_POS = 0;

   // set/clear request pair feeding one status bit
   typedef struct packed {
      logic set;
      logic clr;
   } bit_evt_t;

endpackage

// File: rtl/ep0nak_clr_delay.sv
module ep0nak_clr_delay #(
   parameter int DELAY = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_i,
   output logic cmd_o
);

   // the status bit register supplies the last stage of the delay
   localparam int STAGES = DELAY - 1;

   if (DELAY < 1 || DELAY > 64) begin : g_bad_delay
      $error("ep0nak_clr_delay: DELAY must be within 1..64");
   end

   if (STAGES == 0) begin : g_direct
      assign cmd_o = cmd_i;
   end else begin : g_pipe
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr_q <= '0;
         else if (STAGES == 1) sr_q <= cmd_i;
         else sr_q <= {sr_q[STAGES-2+((STAGES>1)?0:1):0], cmd_i};
      end
      assign cmd_o = sr_q[STAGES-1];

      // R9
      pipe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cmd_i |=> sr_q[0]);
   end

endmodule

// File: rtl/ep0nak_bit_cell.sv
module ep0nak_bit_cell
   import ep0nak_pkg::*;
#(
   parameter logic RST_VAL = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  bit_evt_t evt,
   output logic     q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RST_VAL;
      else if (evt.clr) q <= 1'b0;
      else if (evt.set) q <= 1'b1;
   end

   // R10
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.clr |=> !q);

   // R4
   set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.set && !evt.clr) |=> q);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt.set && !evt.clr) |=> $stable(q));

endmodule

// File: rtl/ep0nak_token_decide.sv
module ep0nak_token_decide #(
   parameter logic NAK_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tok,
   input  logic state_q,
   output logic nak_o,
   output logic go_o
);

   logic refuse;

   if (NAK_LEVEL) begin : g_nak_high
      assign refuse = state_q;
   end else begin : g_nak_low
      assign refuse = !state_q;
   end

   assign nak_o = tok & refuse;
   assign go_o  = tok & !refuse;

   // R2
   one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tok |-> $onehot({nak_o, go_o}));

   // R3
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tok |-> (!nak_o && !go_o));

endmodule

// File: rtl/ep0_nak_ctrl.sv
module ep0_nak_ctrl
   import ep0nak_pkg::*;
#(
   parameter int REG_W     = 8,
   parameter int CLR_DELAY = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fw_wr,
   input  logic [REG_W-1:0] fw_wdata,
   output logic [REG_W-1:0] fw_rdata,
   input  logic             rx_good,
   input  logic             rx_drained,
   input  logic             rx_clr_cmd,
   input  logic             ep_nak_busy,
   input  logic             tx_host_ack,
   input  logic             tx_full,
   input  logic             tx_short_end,
   input  logic             tx_clr_cmd,
   input  logic             status_no_ack,
   input  logic             out_tok,
   input  logic             in_tok,
   output logic             out_nak,
   output logic             out_ack,
   output logic             in_nak,
   output logic             in_send
);

   localparam int TOP_POS = (RX_NAK_POS > TX_RDY_POS) ? RX_NAK_POS : TX_RDY_POS;

   if (REG_W <= TOP_POS) begin : g_bad_width
      $error("ep0_nak_ctrl: REG_W too small for the status bits");
   end

   logic     rx_clr_late, tx_clr_late;
   logic     rx_q, tx_q;
   logic     fw_take;
   bit_evt_t rx_evt, tx_evt;

   ep0nak_clr_delay #(.DELAY(CLR_DELAY)) u_rx_dly (
      .clk(clk), .rst_n(rst_n), .cmd_i(rx_clr_cmd), .cmd_o(rx_clr_late));

   ep0nak_clr_delay #(.DELAY(CLR_DELAY)) u_tx_dly (
      .clk(clk), .rst_n(rst_n), .cmd_i(tx_clr_cmd), .cmd_o(tx_clr_late));

   assign fw_take = fw_wr && !ep_nak_busy;

   always_comb begin
      rx_evt.clr = rx_clr_late || rx_drained || (fw_take && !fw_wdata[RX_NAK_POS]);
      rx_evt.set = rx_good || (fw_take && fw_wdata[RX_NAK_POS]);
      tx_evt.clr = tx_clr_late || status_no_ack || tx_host_ack;
      tx_evt.set = tx_full || tx_short_end;
   end

   ep0nak_bit_cell #(.RST_VAL(1'b0)) u_rx_bit (
      .clk(clk), .rst_n(rst_n), .evt(rx_evt), .q(rx_q));

   ep0nak_bit_cell #(.RST_VAL(1'b0)) u_tx_bit (
      .clk(clk), .rst_n(rst_n), .evt(tx_evt), .q(tx_q));

   always_comb begin
      fw_rdata             = '0;
      fw_rdata[RX_NAK_POS] = rx_q;
      fw_rdata[TX_RDY_POS] = tx_q;
   end

   ep0nak_token_decide #(.NAK_LEVEL(1'b1)) u_out_dec (
      .clk(clk), .rst_n(rst_n), .tok(out_tok), .state_q(rx_q),
      .nak_o(out_nak), .go_o(out_ack));

   ep0nak_token_decide #(.NAK_LEVEL(1'b0)) u_in_dec (
      .clk(clk), .rst_n(rst_n), .tok(in_tok), .state_q(tx_q),
      .nak_o(in_nak), .go_o(in_send));

   // R1
   spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fw_rdata) <= 2 && fw_rdata[REG_W-1:TOP_POS+1] == '0);

   // R6
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_wr && ep_nak_busy && !rx_good && !rx_drained && !rx_clr_late)
         |=> $stable(rx_q));

   // R8
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_no_ack |=> !tx_q);

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_host_ack |=> !tx_q);

endmodule

// File: tb/sim_ep0_nak_ctrl.sv
module sim_ep0_nak_ctrl;

   localparam int REG_W     = 8;
   localparam int CLR_DELAY = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic             rst_n;
   logic             fw_wr, rx_good, rx_drained, rx_clr_cmd, ep_nak_busy;
   logic             tx_host_ack, tx_full, tx_short_end, tx_clr_cmd, status_no_ack;
   logic             out_tok, in_tok;
   logic [REG_W-1:0] fw_wdata, fw_rdata;
   logic             out_nak, out_ack, in_nak, in_send;

   ep0_nak_ctrl #(.REG_W(REG_W), .CLR_DELAY(CLR_DELAY)) u0 (
      .clk(clk), .rst_n(rst_n), .fw_wr(fw_wr), .fw_wdata(fw_wdata),
      .fw_rdata(fw_rdata), .rx_good(rx_good), .rx_drained(rx_drained),
      .rx_clr_cmd(rx_clr_cmd), .ep_nak_busy(ep_nak_busy),
      .tx_host_ack(tx_host_ack), .tx_full(tx_full), .tx_short_end(tx_short_end),
      .tx_clr_cmd(tx_clr_cmd), .status_no_ack(status_no_ack),
      .out_tok(out_tok), .in_tok(in_tok), .out_nak(out_nak), .out_ack(out_ack),
      .in_nak(in_nak), .in_send(in_send));

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 0;

   // behavioural reference: two bits plus queues of pending clear edges
   bit m_rx, m_tx;
   int edge_no;
   int rxq[$];
   int txq[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rx = 0; m_tx = 0; edge_no = 0;
         rxq.delete(); txq.delete();
      end else begin
         bit rce, tce, fw_ok, c, s;
         if (rx_clr_cmd) rxq.push_back(edge_no + CLR_DELAY - 1);
         if (tx_clr_cmd) txq.push_back(edge_no + CLR_DELAY - 1);
         rce = 0; tce = 0;
         if (rxq.size() > 0 && rxq[0] == edge_no) begin rce = 1; void'(rxq.pop_front()); end
         if (txq.size() > 0 && txq[0] == edge_no) begin tce = 1; void'(txq.pop_front()); end
         fw_ok = fw_wr && !ep_nak_busy;
         c = rce || rx_drained || (fw_ok && !fw_wdata[1]);
         s = rx_good || (fw_ok && fw_wdata[1]);
         if (c) m_rx = 0; else if (s) m_rx = 1;
         c = tce || status_no_ack || tx_host_ack;
         s = tx_full || tx_short_end;
         if (c) m_tx = 0; else if (s) m_tx = 1;
         edge_no++;
      end
   end

   task automatic cmp(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   // compare every cycle, before new stimulus lands
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cmp("rdata", fw_rdata, {6'b0, m_rx, m_tx});
         cmp("out_nak", out_nak, out_tok && m_rx);
         cmp("out_ack", out_ack, out_tok && !m_rx);
         cmp("in_nak", in_nak, in_tok && !m_tx);
         cmp("in_send", in_send, in_tok && m_tx);
      end
   end

   task automatic nx();
      @(negedge clk); #2;
      fw_wr = 0; fw_wdata = '0; rx_good = 0; rx_drained = 0; rx_clr_cmd = 0;
      ep_nak_busy = 0; tx_host_ack = 0; tx_full = 0; tx_short_end = 0;
      tx_clr_cmd = 0; status_no_ack = 0; out_tok = 0; in_tok = 0;
   endtask

   task automatic tok_both();
      nx(); out_tok = 1; in_tok = 1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      rst_n = 0;
      fw_wr = 0; fw_wdata = '0; rx_good = 0; rx_drained = 0; rx_clr_cmd = 0;
      ep_nak_busy = 0; tx_host_ack = 0; tx_full = 0; tx_short_end = 0;
      tx_clr_cmd = 0; status_no_ack = 0; out_tok = 0; in_tok = 0;
      repeat (3) @(posedge clk);
      #3 rst_n = 1;
      // R1 reset state, then R2/R3 decisions at reset values
      cur_req = "R1"; nx(); nx();
      cur_req = "R2"; tok_both(); tok_both();
      // R4 good receive sets, drain clears
      cur_req = "R4"; nx(); rx_good = 1; tok_both(); nx(); rx_drained = 1; tok_both();
      // R5 firmware set and clear; stray bits ignored
      cur_req = "R5"; nx(); fw_wr = 1; fw_wdata = 8'hFF; tok_both();
      nx(); fw_wr = 1; fw_wdata = 8'hFD; tok_both();
      nx(); fw_wr = 1; fw_wdata = 8'h02; tok_both();
      // R6 write blocked while busy
      cur_req = "R6"; nx(); fw_wr = 1; fw_wdata = 8'h00; ep_nak_busy = 1; tok_both();
      nx(); fw_wr = 1; fw_wdata = 8'h00; tok_both();
      nx(); fw_wr = 1; fw_wdata = 8'h02; ep_nak_busy = 1; tok_both();
      // R7 transmit arm and host ack
      cur_req = "R3"; nx(); tx_full = 1; tok_both();
      cur_req = "R7"; nx(); tx_host_ack = 1; tok_both();
      nx(); tx_short_end = 1; tok_both();
      // R8 status stage without ack
      cur_req = "R8"; nx(); status_no_ack = 1; tok_both();
      // R10 collisions
      cur_req = "R10"; nx(); rx_good = 1; rx_drained = 1; nx();
      nx(); tx_full = 1; tx_host_ack = 1; tok_both();
      // R9 delayed clear tracked edge by edge; firmware set during wait
      cur_req = "R9"; nx(); rx_good = 1; tx_full = 1;
      nx(); rx_clr_cmd = 1; tx_clr_cmd = 1;
      for (int i = 0; i < CLR_DELAY + 2; i++) begin
         nx(); out_tok = 1; in_tok = 1;
         if (i == CLR_DELAY - 3) begin cur_req = "R10"; fw_wr = 1; fw_wdata = 8'h02; tx_full = 1; end
      end
      cur_req = "R9"; nx(); nx();
      // random interaction phase
      cur_req = "R10";
      for (int n = 0; n < 3000; n++) begin
         nx();
         rx_good      = ($urandom % 6) == 0;
         rx_drained   = ($urandom % 7) == 0;
         rx_clr_cmd   = ($urandom % 23) == 0;
         ep_nak_busy  = ($urandom % 3) == 0;
         fw_wr        = ($urandom % 5) == 0;
         fw_wdata     = 8'($urandom);
         tx_host_ack  = ($urandom % 7) == 0;
         tx_full      = ($urandom % 6) == 0;
         tx_short_end = ($urandom % 9) == 0;
         tx_clr_cmd   = ($urandom % 23) == 0;
         status_no_ack = ($urandom % 31) == 0;
         out_tok      = $urandom % 2;
         in_tok       = $urandom % 2;
      end
      repeat (CLR_DELAY + 2) nx();
      finish_run();
   end

endmodule